// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block drives a three-wire serial EEPROM that stores 16-bit words. It has four device pins: an active-high select, a serial clock, a serial data line towards the device, and the device's data output. A client asks for a run of consecutive word reads or word writes by giving a start offset, a word count and a direction. The controller first checks that the request fits inside the device. It then sends every word as a separately framed command: start bit, opcode and address go out most significant bit first, and the 16 data bits follow, either shifted in or shifted out.

A write run is enclosed between an erase/write-enable command and an erase/write-disable command. Both use an opcode field two bits wider and an address field two bits narrower than an ordinary command. After each written word the controller returns the bus to standby and samples the device output until the device reports ready. It gives up after a bounded number of samples. Read words come out one at a time with a strobe. Write words are taken from the client on a pull strobe. One done pulse with a status code closes every request. The serial clock half-period is set at run time as a count of system clocks.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, `ee_cs`, `ee_sk` and `ee_di` are low. `done` and `rd_valid` are also low after reset.
- R2: A request is rejected in the cycle after it is taken, with `done` high and `err` = 1, and `ee_cs` never rises, if any of these holds: the offset is at least 2^ADDR_W, the count is zero, or the count is larger than 2^ADDR_W minus the offset.
- R3: A read of N words issues N framed commands, each made of start bit 1, opcode bits 10 and the word address, for the addresses offset to offset+N-1 in ascending order. Each word is followed by 16 bits shifted in MSB first, and then by one `rd_valid` pulse carrying the word.
- R4: Each data bit is presented on `ee_di` while `ee_sk` is low and stays stable while `ee_sk` is high. A data-bit clock pulse is high for exactly half_period+1 system clocks. The standby clock pulse is high for twice that.
- R5: `ee_di` stays low while read data is shifted in.
- R6: A write run sends the enable command (start 1, opcode 00, address top bits 11) before the first word. It sends start 1, opcode 01, the address and 16 data bits for each word. It closes with the disable command (start 1, opcode 00, address top bits 00). Each word lands at offset plus its index.
- R7: After each written word the bus goes to standby and `ee_do` is sampled once per half-period with select high. No further command starts until `ee_do` has been seen high.
- R8: If `ee_do` stays low for POLL_MAX samples after a word, the run stops without the disable command. The block then drops select and pulses `done` with `err` = 2. Later words are neither pulled nor written.
- R9: `wr_pull` pulses once per written word. The value on `wr_data` in that cycle's preceding clock edge is the word that gets written.
- R10: Every accepted request ends with exactly one single-cycle `done` pulse. `err` is 0 when all words completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HALF_W | Serial clock half-period minus one, in system clocks |
| req_valid | input | 1 | Request strobe, taken while `busy` is low |
| req_write | input | 1 | 1 = write run, 0 = read run |
| req_offset | input | ADDR_W+1 | First word address |
| req_count | input | ADDR_W+1 | Number of words |
| wr_data | input | 16 | Word to write, sampled when the word's transfer starts |
| wr_pull | output | 1 | Pulse: current write word taken |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new word |
| done | output | 1 | Pulse: request finished |
| err | output | 2 | Status with `done`: 0 ok, 1 range, 2 write timeout |
| busy | output | 1 | A request is in progress |
| ee_cs | output | 1 | Device select, active high |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data / ready from the device |

## Verification
The bench attaches a behavioural EEPROM model that decodes framed commands, models the write enable latch and keeps a busy time after each write. Reads are run at the first word, at the last word, over the whole device, and at a slower half-period. Together these separate address sequencing from data shifting and from clock timing. Writes with a short busy time show enable/disable framing and ready polling. A device that never becomes ready separates the timeout path from normal completion. Three out-of-range requests cover each rejection condition in turn: offset, zero count, and count overflow.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_PREP, SQ_EWEN, SQ_EWEN_A, SQ_OP, SQ_ADDR, SQ_WDATA,
        SQ_RDATA, SQ_STBY, SQ_POLL, SQ_EWDS, SQ_EWDS_A, SQ_END
    } seq_st_e;

    typedef enum logic [1:0] {SD_IDLE, SD_LO, SD_HI} sd_st_e;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_RANGE   = 2'd1;
    localparam logic [1:0] ERR_TIMEOUT = 2'd2;

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_period,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= half_period);
        cnt_d = tick ? '0 : cnt_q + HALF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_serdes.sv
module mw_serdes
    import mw_pkg::*;
#(
    parameter int FW   = 16,
    parameter int NB_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start,
    input  logic            dir_in,
    input  logic [NB_W-1:0] nbits,
    input  logic [FW-1:0]   data,
    input  logic            sdo,
    output logic            sk,
    output logic            sdi,
    output logic            done,
    output logic [FW-1:0]   rdata
);
    typedef struct packed {
        sd_st_e          st;
        logic [FW-1:0]   sr;
        logic [FW-1:0]   rd;
        logic [NB_W-1:0] left;
        logic            dir;
        logic            done;
    } sd_t;

    sd_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.st)
            SD_IDLE: if (start) begin
                n.sr   = data << (FW - int'(nbits));
                n.left = nbits;
                n.dir  = dir_in;
                n.st   = SD_LO;
            end
            SD_LO: if (tick) n.st = SD_HI;
            SD_HI: if (tick) begin
                n.rd = {q.rd[FW-2:0], sdo};
                n.sr = q.sr << 1;
                if (q.left == NB_W'(1)) begin
                    n.st   = SD_IDLE;
                    n.done = 1'b1;
                end else begin
                    n.left = q.left - NB_W'(1);
                    n.st   = SD_LO;
                end
            end
            default: n.st = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SD_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sk    = (q.st == SD_HI);
    assign sdi   = (q.st != SD_IDLE) && !q.dir && q.sr[FW-1];
    assign done  = q.done;
    assign rdata = q.rd;
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int          OP_W     = 3,
    parameter int          HALF_W   = 8,
    parameter int          POLL_MAX = 200,
    parameter logic [15:0] OPC_RD   = 16'h0006,
    parameter logic [15:0] OPC_WR   = 16'h0005,
    parameter logic [15:0] OPC_WEN  = 16'h0013,
    parameter logic [15:0] OPC_WDS  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_period,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W:0]   req_offset,
    input  logic [ADDR_W:0]   req_count,
    input  logic [15:0]       wr_data,
    output logic              wr_pull,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic [1:0]        err,
    output logic              busy,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int WORDS  = 1 << ADDR_W;
    localparam int CNT_W  = ADDR_W + 1;
    localparam int POLL_W = $clog2(POLL_MAX);
    localparam int NB_W   = $clog2(WORD_W + 1);

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           ret;
        logic [1:0]        ph;
        logic              launched;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  idx;
        logic [POLL_W-1:0] poll;
        logic              cs;
        logic              sk;
        logic              done;
        logic [1:0]        err;
        logic [1:0]        errp;
        logic              rdv;
        logic [15:0]       rdw;
        logic              pull;
    } sq_t;

    sq_t q, n;

    logic              tick;
    logic              ser_start, ser_done, ser_sk, ser_di, f_dir;
    logic [NB_W-1:0]   f_bits;
    logic [WORD_W-1:0] f_data, ser_rdata;
    logic [CNT_W:0]    off_x, cnt_x, room;
    logic              range_bad, last;
    logic [CNT_W-1:0]  idx_nx;
    logic [ADDR_W-1:0] word_addr;

    mw_tick #(.HALF_W(HALF_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .tick(tick)
    );

    mw_serdes #(.FW(WORD_W), .NB_W(NB_W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(ser_start),
        .dir_in(f_dir), .nbits(f_bits), .data(f_data), .sdo(ee_do),
        .sk(ser_sk), .sdi(ser_di), .done(ser_done), .rdata(ser_rdata)
    );

    always_comb begin
        off_x     = {1'b0, req_offset};
        cnt_x     = {1'b0, req_count};
        room      = (CNT_W+1)'(WORDS) - off_x;
        range_bad = (off_x >= (CNT_W+1)'(WORDS)) || (cnt_x == '0) || (cnt_x > room);
        idx_nx    = q.idx + CNT_W'(1);
        last      = (idx_nx == q.cnt);
        word_addr = q.base + q.idx[ADDR_W-1:0];
    end

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        n.rdv     = 1'b0;
        n.pull    = 1'b0;
        ser_start = 1'b0;
        f_bits    = '0;
        f_data    = '0;
        f_dir     = 1'b0;

        // field selection for the bit engine
        case (q.st)
            SQ_EWEN:   begin f_bits = NB_W'(OP_W + 2); f_data = OPC_WEN; end
            SQ_EWDS:   begin f_bits = NB_W'(OP_W + 2); f_data = OPC_WDS; end
            SQ_EWEN_A,
            SQ_EWDS_A: f_bits = NB_W'(ADDR_W - 2);
            SQ_OP:     begin f_bits = NB_W'(OP_W); f_data = q.wr ? OPC_WR : OPC_RD; end
            SQ_ADDR:   begin f_bits = NB_W'(ADDR_W); f_data = WORD_W'(word_addr); end
            SQ_WDATA:  begin f_bits = NB_W'(WORD_W); f_data = wr_data; end
            SQ_RDATA:  begin f_bits = NB_W'(WORD_W); f_dir = 1'b1; end
            default:   f_bits = '0;
        endcase

        case (q.st)
            SQ_IDLE: if (req_valid) begin
                if (range_bad) begin
                    n.done = 1'b1;
                    n.err  = ERR_RANGE;
                end else begin
                    n.st   = SQ_PREP;
                    n.ph   = 2'd0;
                    n.wr   = req_write;
                    n.base = req_offset[ADDR_W-1:0];
                    n.cnt  = req_count;
                    n.idx  = '0;
                    n.errp = ERR_NONE;
                end
            end
            SQ_PREP: if (tick) begin
                if (q.ph == 2'd0) begin
                    n.cs = 1'b0;
                    n.sk = 1'b0;
                    n.ph = 2'd1;
                end else begin
                    n.cs = 1'b1;
                    n.ph = 2'd0;
                    n.st = q.wr ? SQ_EWEN : SQ_OP;
                end
            end
            SQ_STBY: if (tick) begin
                case (q.ph)
                    2'd0: begin n.cs = 1'b0; n.sk = 1'b0; end
                    2'd1: n.sk = 1'b1;
                    2'd2: n.cs = 1'b1;
                    default: begin n.sk = 1'b0; n.st = q.ret; end
                endcase
                n.ph = q.ph + 2'd1;
            end
            SQ_POLL: if (tick) begin
                if (ee_do) begin
                    n.idx  = idx_nx;
                    n.st   = SQ_STBY;
                    n.ph   = 2'd0;
                    n.ret  = last ? SQ_EWDS : SQ_OP;
                    n.poll = '0;
                end else if (q.poll == POLL_W'(POLL_MAX - 1)) begin
                    n.errp = ERR_TIMEOUT;
                    n.st   = SQ_END;
                end else begin
                    n.poll = q.poll + POLL_W'(1);
                end
            end
            SQ_END: if (tick) begin
                n.cs   = 1'b0;
                n.sk   = 1'b0;
                n.done = 1'b1;
                n.err  = q.errp;
                n.st   = SQ_IDLE;
            end
            default: begin
                if (!q.launched) begin
                    ser_start  = 1'b1;
                    n.launched = 1'b1;
                    n.pull     = (q.st == SQ_WDATA);
                end else if (ser_done) begin
                    n.launched = 1'b0;
                    case (q.st)
                        SQ_EWEN:   n.st = SQ_EWEN_A;
                        SQ_EWEN_A: begin n.st = SQ_STBY; n.ph = 2'd0; n.ret = SQ_OP; end
                        SQ_OP:     n.st = SQ_ADDR;
                        SQ_ADDR:   n.st = q.wr ? SQ_WDATA : SQ_RDATA;
                        SQ_WDATA:  begin
                            n.st   = SQ_STBY;
                            n.ph   = 2'd0;
                            n.ret  = SQ_POLL;
                            n.poll = '0;
                        end
                        SQ_RDATA:  begin
                            n.rdv = 1'b1;
                            n.rdw = ser_rdata;
                            n.idx = idx_nx;
                            n.st  = SQ_STBY;
                            n.ph  = 2'd0;
                            n.ret = last ? SQ_END : SQ_OP;
                        end
                        SQ_EWDS:   n.st = SQ_EWDS_A;
                        SQ_EWDS_A: n.st = SQ_END;
                        default:   n.st = SQ_END;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= SQ_IDLE;
            q.ret <= SQ_IDLE;
        end else begin
            q <= n;
        end
    end

    assign wr_pull  = q.pull;
    assign rd_data  = q.rdw;
    assign rd_valid = q.rdv;
    assign done     = q.done;
    assign err      = q.err;
    assign busy     = (q.st != SQ_IDLE);
    assign ee_cs    = q.cs;
    assign ee_sk    = q.sk | ser_sk;
    assign ee_di    = ser_di;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int ADDR_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [ADDR_W:0] req_offset,
    input logic [ADDR_W:0] req_count,
    input logic            busy,
    input logic            done,
    input logic [1:0]      err,
    input logic            rd_valid,
    input logic            wr_pull,
    input logic            ee_cs,
    input logic            ee_sk,
    input logic            ee_di
);
    localparam int LIM = 1 << ADDR_W;

    logic [ADDR_W+1:0] o_w, c_w;
    logic              req_bad;

    always_comb begin
        o_w     = {1'b0, req_offset};
        c_w     = {1'b0, req_count};
        req_bad = (o_w >= (ADDR_W+2)'(LIM)) || (c_w == '0) ||
                  ((c_w + o_w) > (ADDR_W+2)'(LIM));
    end

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sk && !ee_di)); // R1
    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_bad) |=> (done && err == 2'd1 && !ee_cs)); // R2
    AST_RDVALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !wr_pull)); // R3
    AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R4
    AST_PULL_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pull |-> busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind mw_eeprom_ctrl mw_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .wr_pull(wr_pull), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di)
);

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_period = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [AW:0] req_offset = '0;
    logic [AW:0] req_count = '0;
    logic [15:0] wr_data;
    logic        wr_pull, rd_valid, done, busy, ee_cs, ee_sk, ee_di;
    logic [15:0] rd_data;
    logic [1:0]  err;
    logic        ee_do;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    mw_eeprom_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
        .req_count(req_count), .wr_data(wr_data), .wr_pull(wr_pull),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .busy(busy), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- behavioural EEPROM model ----------------
    logic [15:0]   mem [0:NW-1];
    int            mstate = 0, nb = 0, rk = 0;
    logic [AW+1:0] cmd = '0;
    logic [AW-1:0] raddr = '0, waddr = '0;
    logic [15:0]   wd = '0;
    logic          pend = 1'b0, wen = 1'b0, mdo = 1'b1, psk = 1'b0, pcs = 1'b0;
    int            busy_left = 0, busy_len = 30;
    int            di_bad = 0, busy_viol = 0, cs_rises = 0, wr_blocked = 0;
    int            hrun = 0, hmin = 1000, hmax = 0;

    assign ee_do = mdo;

    always @(negedge clk) begin
        logic [AW+1:0] c;
        if (busy_left > 0) busy_left--;
        if (ee_cs && !pcs) begin cs_rises++; mstate = 0; end
        if (!ee_cs && pcs) begin
            if (pend) begin
                if (wen) begin mem[waddr] = wd; busy_left = busy_len; end
                else wr_blocked++;
                pend = 1'b0;
            end
            mstate = 0;
        end
        if (ee_cs && ee_sk && !psk) begin
            case (mstate)
                0: if (ee_di) begin
                    if (busy_left > 0) busy_viol++;
                    mstate = 1; nb = 0; cmd = '0;
                end
                1: begin
                    c = {cmd[AW:0], ee_di}; cmd = c; nb++;
                    if (nb == AW + 2) begin
                        case (c[AW+1:AW])
                            2'b10: begin mstate = 2; rk = 0; raddr = c[AW-1:0]; mdo = 1'b0; end
                            2'b01: begin mstate = 3; nb = 0; waddr = c[AW-1:0]; end
                            default: begin
                                if (c[AW-1:AW-2] == 2'b11) wen = 1'b1;
                                if (c[AW-1:AW-2] == 2'b00) wen = 1'b0;
                                mstate = 4;
                            end
                        endcase
                    end
                end
                2: begin
                    if (ee_di) di_bad++;
                    mdo = mem[raddr][15-rk]; rk++;
                    if (rk == 16) mstate = 4;
                end
                3: begin
                    wd = {wd[14:0], ee_di}; nb++;
                    if (nb == 16) begin pend = 1'b1; mstate = 4; end
                end
                default: ;
            endcase
        end
        if (ee_cs && mstate == 0) mdo = (busy_left == 0);
        if (ee_sk) hrun++;
        else if (hrun > 0) begin
            if (hrun < hmin) hmin = hrun;
            if (hrun > hmax) hmax = hrun;
            hrun = 0;
        end
        psk = ee_sk; pcs = ee_cs;
    end

    // ---------------- write data supply ----------------
    int          pull_cnt = 0;
    logic [15:0] wbase = 16'h0;

    function automatic logic [15:0] wr_word(logic [15:0] b, int k);
        return b ^ 16'(k * 16'h0111 + 7);
    endfunction

    assign wr_data = wr_word(wbase, pull_cnt);

    always @(negedge clk) if (wr_pull) pull_cnt++;

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    int nrd;
    int done_lat;
    logic [1:0] last_err;

    // issue a request and run until done; read words are checked as they come
    task automatic run_req(input bit wr, input int off, input int cnt);
        int lim;
        nrd = 0; done_lat = 0; lim = 0;
        @(negedge clk);
        req_write = wr; req_offset = (AW+1)'(off); req_count = (AW+1)'(cnt);
        req_valid = 1'b1;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            done_lat++; lim++;
            if (rd_valid) begin
                chk(rd_data == mem[(off + nrd) % NW], "R3 read word",
                    int'(rd_data), int'(mem[(off + nrd) % NW]));
                nrd++;
            end
        end while (!done && lim < 30000);
        chk(done == 1'b1, "R10 done reached", int'(done), 1);
        last_err = err;
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(!ee_cs && !ee_sk && !ee_di, "R1 bus low after reset",
            int'({ee_cs, ee_sk, ee_di}), 0);
        chk(!done && !rd_valid && !busy, "R1 status low after reset",
            int'({done, rd_valid, busy}), 0);
    endtask

    task automatic t_range(input int off, input int cnt);
        int cr0;
        cr0 = cs_rises;
        run_req(1'b0, off, cnt);
        chk(done_lat == 1, "R2 reject latency", done_lat, 1);
        chk(last_err == 2'd1, "R2 range error code", int'(last_err), 1);
        chk(cs_rises == cr0, "R2 no select activity", cs_rises - cr0, 0);
        chk(nrd == 0, "R2 no words", nrd, 0);
    endtask

    task automatic t_read(input int off, input int cnt);
        int db0;
        db0 = di_bad; hmin = 1000; hmax = 0;
        run_req(1'b0, off, cnt);
        chk(last_err == 2'd0, "R10 read ok code", int'(last_err), 0);
        chk(nrd == cnt, "R3 word count", nrd, cnt);
        chk(di_bad == db0, "R5 DI low while shifting in", di_bad - db0, 0);
        chk(hmin == int'(half_period) + 1, "R4 bit clock high time", hmin, int'(half_period) + 1);
        chk(hmax == 2 * (int'(half_period) + 1), "R4 standby clock high time",
            hmax, 2 * (int'(half_period) + 1));
        chk(!ee_cs && !ee_sk && !busy, "R1 bus released after read",
            int'({ee_cs, ee_sk, busy}), 0);
    endtask

    task automatic t_write(input int off, input int cnt, input logic [15:0] b);
        int bv0, wb0;
        bv0 = busy_viol; wb0 = wr_blocked;
        wbase = b; pull_cnt = 0; busy_len = 30;
        run_req(1'b1, off, cnt);
        chk(last_err == 2'd0, "R10 write ok code", int'(last_err), 0);
        chk(pull_cnt == cnt, "R9 one pull per word", pull_cnt, cnt);
        for (int k = 0; k < cnt; k++)
            chk(mem[off + k] == wr_word(b, k), "R6 word stored at address",
                int'(mem[off + k]), int'(wr_word(b, k)));
        chk(wr_blocked == wb0, "R6 enable sent before writes", wr_blocked - wb0, 0);
        chk(wen == 1'b0, "R6 disable sent after run", int'(wen), 0);
        chk(busy_viol == bv0, "R7 no command while device busy", busy_viol - bv0, 0);
        // the written words read back through the port
        t_read(off, cnt);
    endtask

    task automatic t_timeout;
        logic [15:0] keep1, keep2;
        keep1 = mem[21]; keep2 = mem[22];
        wbase = 16'h5A5A; pull_cnt = 0; busy_len = 1000000;
        run_req(1'b1, 20, 3);
        chk(last_err == 2'd2, "R8 timeout error code", int'(last_err), 2);
        chk(pull_cnt == 1, "R8 later words not pulled", pull_cnt, 1);
        chk(mem[20] == wr_word(16'h5A5A, 0), "R8 first word programmed",
            int'(mem[20]), int'(wr_word(16'h5A5A, 0)));
        chk(mem[21] == keep1 && mem[22] == keep2, "R8 later words untouched",
            int'(mem[21]), int'(keep1));
        chk(wen == 1'b1, "R8 no disable command after timeout", int'(wen), 1);
        chk(!ee_cs && !busy, "R8 select dropped", int'({ee_cs, busy}), 0);
        busy_left = 0; busy_len = 30;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 16'hA5C3 ^ 16'(i * 311);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_range(NW, 1);
        t_range(5, 0);
        t_range(60, 5);
        t_read(0, 1);
        t_read(NW - 1, 1);
        t_read(10, 4);
        t_read(0, NW);
        t_write(3, 3, 16'hC0DE);
        t_write(NW - 2, 2, 16'h1234);
        t_timeout;
        half_period = 8'd3;
        t_read(30, 2);
        t_write(40, 1, 16'hBEEF);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule